// File: doc/BRIEF.md
# Cartridge Memory Bank Controller

This block sits between an 8-bit processor bus with a 16-bit address and two external arrays: a banked program ROM and a banked cartridge RAM. The lower half of the address map reads ROM. It is split into a fixed 16 KiB window and a switchable 16 KiB window. Writes aimed at that same half do not reach the ROM. Instead they land in write-only control slices. These slices hold the RAM enable, the switchable ROM bank and the RAM bank selection. An 8 KiB window at 0xA000 reaches the cartridge RAM through its own bank register.

The block drives the physical ROM and RAM addresses combinationally from the bus address and the current bank state. Both arrays are synchronous, so they return data one cycle later. The block registers the source of each read and steers the matching byte onto the read-data output in the following cycle, together with a valid strobe. Some reads cannot reach a populated array: RAM while it is disabled, a register slot, or an address outside every decoded range. These return a fixed byte and never stall the bus.

Top module: `cart_bank_ctrl`

## Requirements
- R1: A read in 0x0000–0x3FFF presents ROM address equal to the bus address, with the upper ROM address bits zero, whatever the bank state.
- R2: A read in 0x4000–0x7FFF presents ROM address (addr − 0x4000) + bank × 0x4000. A stored bank value of 0 is used as bank 1.
- R3: A write in 0x2000–0x3FFF stores the written byte ANDed with 0x7F as the ROM bank value.
- R4: The ROM bank in use is the adjusted bank of R2 reduced modulo ROM_BANKS, a power of two. A stored value equal to ROM_BANKS therefore maps the switchable window onto bank 0.
- R5: A write in 0x0000–0x1FFF of 0x0A sets the RAM enable and a write of 0x00 clears it. Any other value leaves the enable unchanged.
- R6: RAM selection values 0x00–0x03, written in 0x4000–0x5FFF, choose RAM bank 0–3. An access in 0xA000–0xBFFF then uses RAM address (addr − 0xA000) + bank × 0x2000.
- R7: RAM selection values 0x08–0x0C select a register slot. While a slot is selected, reads in 0xA000–0xBFFF return 0x00 and writes there are dropped. Selection values 0x04–0x07 and 0x0D–0xFF leave the selection unchanged.
- R8: While the RAM enable is clear, reads in 0xA000–0xBFFF return 0xFF and writes there are dropped.
- R9: Writes in 0x6000–0x7FFF change no state. Reads in 0x8000–0x9FFF and 0xC000–0xFFFF return 0xFF, and writes there change no state.
- R10: After reset the ROM bank value is 1, the RAM selection is bank 0, the RAM enable is clear and the read-valid output is low.
- R11: The read data and the read-valid strobe appear in the cycle after the read request. Read-valid is low in every cycle that does not follow a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 16 | Bus address |
| cpuWrData | input | 8 | Bus write byte |
| cpuWr | input | 1 | Write request |
| cpuRd | input | 1 | Read request |
| cpuRdData | output | 8 | Read byte, valid one cycle after the request |
| cpuRdValid | output | 1 | Read byte valid |
| romAddr | output | 14+log2(ROM_BANKS) | Physical ROM address |
| romRdData | input | 8 | ROM byte, one cycle after the address |
| ramAddr | output | 15 | Physical cartridge RAM address |
| ramWrData | output | 8 | RAM write byte |
| ramWr | output | 1 | RAM write strobe |
| ramRdData | input | 8 | RAM byte, one cycle after the address |

## Verification
The bench builds the block with ROM_BANKS set to 8, which gives a 17-bit ROM address. That small count lets a bank write of 0x08 fold onto bank 0 and a write of 0x09 fold onto bank 1, and both wrap cases are compared against the reference. The bench ROM returns a byte computed from its address, so each bank gives distinct data and a wrong bank shows up on the next read. The cartridge RAM is a sparse model, so all four RAM banks and the register slots can be reached.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

  // Where the byte returned one cycle after a read comes from
  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_ROM  = 3'd1,
    SRC_RAM  = 3'd2,
    SRC_ZERO = 3'd3,
    SRC_OPEN = 3'd4
  } rdSrcE;

  // Strobes from control to datapath
  typedef struct packed {
    logic  rdStb;
    rdSrcE rdSrc;
    logic  ramWrStb;
  } ctrlStbT;

  localparam logic [7:0] OPEN_BYTE = 8'hFF;
  localparam logic [7:0] SLOT_BYTE = 8'h00;
  localparam logic [7:0] RAM_ON    = 8'h0A;
  localparam logic [7:0] RAM_OFF   = 8'h00;

endpackage

// File: rtl/cbc_ctrl.sv
module cbc_ctrl
  import cbc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] cpuAddr,
  input  logic [7:0]  cpuWrData,
  input  logic        cpuWr,
  input  logic        cpuRd,
  output logic [6:0]  romBank,
  output logic [3:0]  ramSel,
  output logic        ramEn,
  output ctrlStbT     stb
);

  logic inEnSlice, inRomSlice, inRamSelSlice, inModeSlice, inRamWin, inRom;
  logic ramSelOk, ramUsable;

  // 8 KiB region decode on the top three address bits
  assign inEnSlice     = cpuAddr[15:13] == 3'b000;
  assign inRomSlice    = cpuAddr[15:13] == 3'b001;
  assign inRamSelSlice = cpuAddr[15:13] == 3'b010;
  assign inModeSlice   = cpuAddr[15:13] == 3'b011;
  assign inRamWin      = cpuAddr[15:13] == 3'b101;
  assign inRom         = ~cpuAddr[15];

  assign ramSelOk = (cpuWrData <= 8'h03) ||
                    ((cpuWrData >= 8'h08) && (cpuWrData <= 8'h0C));
  assign ramUsable = ramEn && (ramSel[3:2] == 2'b00);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      romBank <= 7'd1;
      ramSel  <= 4'd0;
      ramEn   <= 1'b0;
    end else if (cpuWr) begin
      if (inEnSlice) begin
        if (cpuWrData == RAM_ON)       ramEn <= 1'b1;
        else if (cpuWrData == RAM_OFF) ramEn <= 1'b0;
      end
      if (inRomSlice) romBank <= cpuWrData[6:0];
      if (inRamSelSlice && ramSelOk) ramSel <= cpuWrData[3:0];
    end
  end

  always_comb begin
    stb.rdStb    = cpuRd;
    stb.ramWrStb = cpuWr && inRamWin && ramUsable;
    if (inRom)              stb.rdSrc = SRC_ROM;
    else if (!inRamWin)     stb.rdSrc = SRC_OPEN;
    else if (!ramEn)        stb.rdSrc = SRC_OPEN;
    else if (!ramUsable)    stb.rdSrc = SRC_ZERO;
    else                    stb.rdSrc = SRC_RAM;
  end

  assert_rom_bank_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWr && cpuAddr[15:13] == 3'b001) |=> (romBank == $past(cpuWrData[6:0])));

  assert_enable_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWr && cpuAddr[15:13] == 3'b000 && cpuWrData != 8'h0A && cpuWrData != 8'h00)
      |=> $stable(ramEn));

  assert_mode_slice_inert_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWr && cpuAddr[15:13] == 3'b011) |=> ($stable(romBank) && $stable(ramSel) && $stable(ramEn)));

  // Unused decode kept visible for the mode slice check above
  logic unusedMode;
  assign unusedMode = inModeSlice;

endmodule

// File: rtl/cbc_datapath.sv
module cbc_datapath
  import cbc_pkg::*;
#(
  parameter int ROM_BANKS = 32,
  localparam int BB       = $clog2(ROM_BANKS),
  localparam int ROM_AW   = 14 + BB
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [14:0]       winOfs,
  input  logic [6:0]        romBank,
  input  logic [1:0]        ramBank,
  input  ctrlStbT           stb,
  input  logic [7:0]        romRdData,
  input  logic [7:0]        ramRdData,
  output logic [ROM_AW-1:0] romAddr,
  output logic [14:0]       ramAddr,
  output logic              ramWr,
  output logic [7:0]        cpuRdData,
  output logic              cpuRdValid
);

  logic [6:0]    nzBank;
  logic [BB-1:0] selBank;
  rdSrcE         rdSrcQ;

  assign nzBank = (romBank == 7'd0) ? 7'd1 : romBank;

  generate
    if (BB == 7) begin : g_fullBank
      assign selBank = nzBank;
    end else begin : g_wrapBank
      logic [6-BB:0] dropBits;
      assign selBank  = nzBank[BB-1:0];
      assign dropBits = nzBank[6:BB];
    end
  endgenerate

  assign romAddr = winOfs[14] ? {selBank, winOfs[13:0]} : {{BB{1'b0}}, winOfs[13:0]};
  assign ramAddr = {ramBank, winOfs[12:0]};
  assign ramWr   = stb.ramWrStb;

  always_ff @(posedge clk) begin
    if (!rstN)          rdSrcQ <= SRC_NONE;
    else if (stb.rdStb) rdSrcQ <= stb.rdSrc;
    else                rdSrcQ <= SRC_NONE;
  end

  always_comb begin
    unique case (rdSrcQ)
      SRC_ROM:  cpuRdData = romRdData;
      SRC_RAM:  cpuRdData = ramRdData;
      SRC_ZERO: cpuRdData = SLOT_BYTE;
      default:  cpuRdData = OPEN_BYTE;
    endcase
  end

  assign cpuRdValid = rdSrcQ != SRC_NONE;

  assert_valid_follows_read_R11: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdStb |=> cpuRdValid);

  assert_valid_needs_read_R11: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdStb |=> !cpuRdValid);

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cbc_pkg::*;
#(
  parameter int ROM_BANKS = 32,
  localparam int ROM_AW   = 14 + $clog2(ROM_BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:0]       cpuAddr,
  input  logic [7:0]        cpuWrData,
  input  logic              cpuWr,
  input  logic              cpuRd,
  output logic [7:0]        cpuRdData,
  output logic              cpuRdValid,
  output logic [ROM_AW-1:0] romAddr,
  input  logic [7:0]        romRdData,
  output logic [14:0]       ramAddr,
  output logic [7:0]        ramWrData,
  output logic              ramWr,
  input  logic [7:0]        ramRdData
);

  logic [6:0] romBank;
  logic [3:0] ramSel;
  logic       ramEn;
  ctrlStbT    stb;

  cbc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData),
    .cpuWr(cpuWr), .cpuRd(cpuRd), .romBank(romBank), .ramSel(ramSel),
    .ramEn(ramEn), .stb(stb)
  );

  cbc_datapath #(.ROM_BANKS(ROM_BANKS)) u_dp (
    .clk(clk), .rstN(rstN), .winOfs(cpuAddr[14:0]), .romBank(romBank),
    .ramBank(ramSel[1:0]), .stb(stb), .romRdData(romRdData),
    .ramRdData(ramRdData), .romAddr(romAddr), .ramAddr(ramAddr),
    .ramWr(ramWr), .cpuRdData(cpuRdData), .cpuRdValid(cpuRdValid)
  );

  assign ramWrData = cpuWrData;

  assert_disabled_ram_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRd && cpuAddr[15:13] == 3'b101 && !ramEn) |=> (cpuRdData == 8'hFF));

  assert_ram_write_gated_R8: assert property (@(posedge clk) disable iff (!rstN)
    ramWr |-> (ramEn && cpuWr));

endmodule

// File: tb/sim_cart_bank_ctrl.sv
module sim_cart_bank_ctrl;

  localparam int NB = 8;
  localparam int AW = 14 + $clog2(NB);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuWrData = '0;
  logic cpuWr = 1'b0, cpuRd = 1'b0;
  logic [7:0] cpuRdData;
  logic cpuRdValid;
  logic [AW-1:0] romAddr;
  logic [7:0] romRdData, ramRdData, ramWrData;
  logic [14:0] ramAddr;
  logic ramWr;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  cart_bank_ctrl #(.ROM_BANKS(NB)) u0 (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData),
    .cpuWr(cpuWr), .cpuRd(cpuRd), .cpuRdData(cpuRdData), .cpuRdValid(cpuRdValid),
    .romAddr(romAddr), .romRdData(romRdData), .ramAddr(ramAddr),
    .ramWrData(ramWrData), .ramWr(ramWr), .ramRdData(ramRdData)
  );

  function automatic logic [7:0] romFn(int a);
    return 8'((a * 7) + ((a >> 14) * 61) + (a >> 8));
  endfunction

  // Bench memories
  logic [7:0] ramMem [int];
  always @(posedge clk) begin
    romRdData <= romFn(int'(romAddr));
    ramRdData <= ramMem.exists(int'(ramAddr)) ? ramMem[int'(ramAddr)] : 8'h00;
    if (ramWr) ramMem[int'(ramAddr)] = ramWrData;
  end

  // Behavioural reference state
  int mRomBank = 1;
  int mRamSel = 0;
  bit mRamEn = 0;
  logic [7:0] mRam [int];

  function automatic logic [7:0] modelRead(int a);
    int b, k;
    if (a < 'h4000) return romFn(a);
    if (a < 'h8000) begin
      b = (mRomBank == 0) ? 1 : mRomBank;
      b = b % NB;
      return romFn(b * 'h4000 + (a - 'h4000));
    end
    if (a >= 'hA000 && a < 'hC000) begin
      if (!mRamEn) return 8'hFF;
      if (mRamSel >= 4) return 8'h00;
      k = mRamSel * 'h2000 + (a - 'hA000);
      return mRam.exists(k) ? mRam[k] : 8'h00;
    end
    return 8'hFF;
  endfunction

  task automatic modelWrite(int a, int d);
    if (a < 'h2000) begin
      if (d == 'h0A) mRamEn = 1;
      else if (d == 0) mRamEn = 0;
    end else if (a < 'h4000) mRomBank = d & 'h7F;
    else if (a < 'h6000) begin
      if (d <= 3 || (d >= 8 && d <= 12)) mRamSel = d;
    end else if (a >= 'hA000 && a < 'hC000) begin
      if (mRamEn && mRamSel < 4) mRam[mRamSel * 'h2000 + (a - 'hA000)] = 8'(d);
    end
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doRd(int a, string req);
    logic [7:0] e;
    @(negedge clk);
    cpuAddr = 16'(a); cpuRd = 1'b1; cpuWr = 1'b0;
    e = modelRead(a);
    @(negedge clk);
    cpuRd = 1'b0;
    check("R11 valid", int'(cpuRdValid), 1);
    check(req, int'(cpuRdData), int'(e));
  endtask

  task automatic doWr(int a, int d);
    @(negedge clk);
    cpuAddr = 16'(a); cpuWrData = 8'(d); cpuWr = 1'b1; cpuRd = 1'b0;
    @(negedge clk);
    cpuWr = 1'b0;
    modelWrite(a, d);
    check("R11 no valid", int'(cpuRdValid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 valid low", int'(cpuRdValid), 0);
    doRd('h4000, "R10 R2 reset bank 1");
    doRd('h0000, "R1 fixed low");
    doRd('h3FFF, "R1 fixed top");
    doRd('hA000, "R10 R8 disabled read");
    doWr('hA000, 'h11);                 // dropped while disabled
    doWr('h0000, 'h0A);
    doRd('hA000, "R8 R5 dropped write then enable");
    doWr('hA000, 'h55);
    doWr('hBFFF, 'hAA);
    doRd('hA000, "R6 bank0 low");
    doRd('hBFFF, "R6 bank0 top");
    doWr('h1000, 'h33);
    doRd('hA000, "R5 other value keeps enable");
    doWr('h4000, 'h02);
    doRd('hA000, "R6 bank2 empty");
    doWr('hA123, 'h77);
    doRd('hA123, "R6 bank2 data");
    doWr('h5FFF, 'h00);
    doRd('hA000, "R6 back to bank0");
    doWr('h4000, 'h08);
    doRd('hA000, "R7 slot read zero");
    doWr('hA000, 'h99);
    doWr('h4000, 'h0C);
    doWr('h4000, 'h05);
    doRd('hA000, "R7 ignored select keeps slot");
    doWr('h4000, 'h00);
    doRd('hA000, "R7 slot write dropped");
    doWr('h2000, 'h00);
    doRd('h4000, "R2 bank0 as bank1");
    doWr('h3000, 'h85);
    doRd('h4ABC, "R3 mask 0x7F");
    doWr('h2000, 'h08);
    doRd('h4000, "R4 wrap to bank 0");
    doWr('h2000, 'h09);
    doRd('h7FFF, "R4 wrap to bank 1");
    doWr('h2000, 'h07);
    doRd('h5555, "R2 bank 7");
    doWr('h6000, 'h01);
    doWr('h7FFF, 'h0A);
    doRd('h4000, "R9 mode slice inert rom");
    doRd('hA000, "R9 mode slice inert ram");
    doRd('h8000, "R9 unmapped low");
    doRd('hC000, "R9 unmapped high");
    doWr('hC000, 'h00);
    doRd('hFFFF, "R9 unmapped write");
    doRd('hA000, "R9 state kept");
    doWr('h0000, 'h00);
    doRd('hA000, "R5 disable");
    doWr('h0000, 'h0A);
    for (int i = 0; i < 60; i++) begin
      int a, d;
      a = (i * 9973 + 131) & 'hFFFF;
      d = (i * 37 + 5) & 'hFF;
      if (i % 5 == 0) doWr('h2000, d);
      else if (i % 5 == 1) doWr('h4000, i & 3);
      else if (i % 5 == 2) doWr('hA000 + (a & 'h1FFF), d);
      doRd(a, "R2 R6 mixed");
      doRd('hA000 + (a & 'h1FFF), "R6 mixed ram");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule